// File: doc/BRIEF.md
# GPE and SCI Interrupt Aggregator

This block keeps a small file of general-purpose event (GPE) status and enable bytes and merges it with the power-management fixed-event status and enable words into one level-sensitive system control interrupt (SCI). Hotplug sources set GPE status bits through a set-pulse vector. Software reaches the GPE bytes through a byte-oriented access port: a request of one to four bytes is split by a small state machine into single-byte beats in little-endian order, one beat per clock.

The window holds `2*GPE_BYTES` bytes. With the default of two GPE bytes, offsets 0 and 1 are the status bytes and offsets 2 and 3 are the enable bytes. A second output asks the power-management timer to arm while the timer event is enabled and its status is still clear. The timer counter, the fixed-event register port and the bus decode above this block are not part of it.

The access state machine has three states. `ACC_IDLE` waits for a request; a start pulse takes the transition *accept* to `ACC_BEAT`. `ACC_BEAT` handles one byte per clock and stays there (*next byte*) until the last byte of the request, where it takes *finish* to `ACC_DONE`. `ACC_DONE` lasts one clock, presents the read data with the done pulse, and takes *release* back to `ACC_IDLE`.

Top module: `gpe_sci_aggregator`

## Requirements
- R1: After reset every GPE status and enable bit reads 0, `sci_o` and `tmr_arm_o` are 0 and `acc_busy_o` is 0.
- R2: Window offsets below `GPE_BYTES` are GPE status bytes and the remaining offsets are GPE enable bytes. Enable bytes read back exactly what was last written.
- R3: Writing a status byte clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R4: A 1 on `evt_set_i[k]` during a clock sets status bit k. When a set and a write-one-to-clear hit the same bit in the same clock, the bit ends up set.
- R5: A request carries `acc_len_i` = byte count minus 1. Byte i of the data (bits 8i+7..8i) maps to window offset `acc_off_i`+i. Bytes at offsets past the end of the window are not written and read as 0. `acc_done_o` pulses for one clock, count+1 clocks after the clock that accepted the request, with `acc_rdata_o` valid in that clock.
- R6: `sci_o` is set by `fix_sts_i & fix_en_i` having any of bit 0 (timer), bit 5 (global lock), bit 8 (power button) or bit 10 (real-time clock). No other fixed bit has any effect.
- R7: `sci_o` is also set when GPE status byte 0 AND enable byte 0 has bit 1 (PCI hotplug) or bit 2 (CPU hotplug) set. No other GPE bit, in either byte, has any effect.
- R8: `sci_o` is registered: it shows, one clock later, the condition formed by the inputs and register contents of the previous clock.
- R9: `tmr_arm_o` is 1 exactly when, in the previous clock, `fix_en_i[0]` was 1 and `fix_sts_i[0]` was 0.
- R10: A start pulse while `acc_busy_o` is 1 is ignored: it writes nothing and produces no further done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_start_i | input | 1 | Starts an access request (taken only when idle) |
| acc_write_i | input | 1 | 1 for write, 0 for read |
| acc_off_i | input | OFF_W (2) | Window offset of the first byte |
| acc_len_i | input | 2 | Byte count minus 1 |
| acc_wdata_i | input | 32 | Write data, byte 0 in bits 7..0 |
| acc_busy_o | output | 1 | Request in progress |
| acc_done_o | output | 1 | One-clock pulse at the end of a request |
| acc_rdata_o | output | 32 | Read data, valid with the done pulse |
| evt_set_i | input | 8*GPE_BYTES (16) | Per-bit GPE status set pulses |
| fix_sts_i | input | FIX_W (16) | Fixed-event status word |
| fix_en_i | input | FIX_W (16) | Fixed-event enable word |
| sci_o | output | 1 | System control interrupt level |
| tmr_arm_o | output | 1 | Request to arm the PM timer |

## Verification
The fixed-event path is driven with each of the four contributing bits alone, with non-contributing bits alone and with the enable word cleared, which separates a correct mask from one that passes extra bits or ignores the enable. The GPE path uses all status bits set while only one enable bit at a time is opened, so that the two hotplug bits are told apart from every other bit and from byte 1. Access requests at the window edge and overlapping start pulses show the byte ordering, the clipping at the end of the window and the guard against requests taken while busy, and a write-one-to-clear aligned with a set pulse in the same clock shows which one wins.

// File: rtl/gpe_sci_pkg.sv
package gpe_sci_pkg;

    // Fixed-event bit positions that may raise the SCI.
    localparam int FIX_TMR_BIT    = 0;
    localparam int FIX_GLK_BIT    = 5;
    localparam int FIX_PWRBTN_BIT = 8;
    localparam int FIX_RTC_BIT    = 10;

    // Hotplug bit positions in GPE byte 0.
    localparam int GPE_PCI_HP_BIT = 1;
    localparam int GPE_CPU_HP_BIT = 2;

    // Access request limits.
    localparam int ACC_MAX_BYTES = 4;
    localparam int ACC_LEN_W     = $clog2(ACC_MAX_BYTES);
    localparam int ACC_DATA_W    = 8 * ACC_MAX_BYTES;

    typedef enum logic [1:0] {
        ACC_IDLE = 2'd0,
        ACC_BEAT = 2'd1,
        ACC_DONE = 2'd2
    } acc_state_e;

    function automatic logic [15:0] fix_sci_mask16();
        logic [15:0] m;
        m = '0;
        m[FIX_TMR_BIT]    = 1'b1;
        m[FIX_GLK_BIT]    = 1'b1;
        m[FIX_PWRBTN_BIT] = 1'b1;
        m[FIX_RTC_BIT]    = 1'b1;
        return m;
    endfunction

    function automatic logic [7:0] gpe_sci_mask8();
        logic [7:0] m;
        m = '0;
        m[GPE_PCI_HP_BIT] = 1'b1;
        m[GPE_CPU_HP_BIT] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/gpe_acc_fsm.sv
module gpe_acc_fsm
    import gpe_sci_pkg::*;
#(
    parameter int WIN   = 4,
    parameter int OFF_W = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    input  logic                  write_i,
    input  logic [OFF_W-1:0]      off_i,
    input  logic [ACC_LEN_W-1:0]  len_i,
    input  logic [ACC_DATA_W-1:0] wdata_i,
    input  logic [7:0]            rd_byte_i,
    output logic                  busy_o,
    output logic                  done_o,
    output logic [ACC_DATA_W-1:0] rdata_o,
    output logic                  bw_en_o,
    output logic [OFF_W-1:0]      b_off_o,
    output logic [7:0]            bw_data_o
);

    localparam int POS_W = OFF_W + ACC_LEN_W + 1;

    acc_state_e            state_q, state_d;
    logic [OFF_W-1:0]      off_q;
    logic [ACC_LEN_W-1:0]  len_q;
    logic [ACC_LEN_W-1:0]  cnt_q;
    logic [ACC_DATA_W-1:0] wdata_q;
    logic [ACC_DATA_W-1:0] rdata_q;
    logic                  write_q;

    logic [POS_W-1:0]      pos;
    logic                  in_win;
    logic                  last_beat;
    logic [ACC_LEN_W+2:0]  lane;

    assign pos       = POS_W'(off_q) + POS_W'(cnt_q);
    assign in_win    = (pos < POS_W'(WIN));
    assign last_beat = (cnt_q == len_q);
    assign lane      = {cnt_q, 3'b000};

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ACC_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ACC_IDLE: if (start_i)   state_d = ACC_BEAT;   // accept
            ACC_BEAT: if (last_beat) state_d = ACC_DONE;   // finish, else next byte
            ACC_DONE:                state_d = ACC_IDLE;   // release
            default:                 state_d = ACC_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        busy_o    = 1'b0;
        done_o    = 1'b0;
        bw_en_o   = 1'b0;
        b_off_o   = pos[OFF_W-1:0];
        bw_data_o = wdata_q[lane +: 8];
        unique case (state_q)
            ACC_IDLE: ;
            ACC_BEAT: begin
                busy_o  = 1'b1;
                bw_en_o = write_q && in_win;
            end
            ACC_DONE: begin
                busy_o = 1'b1;
                done_o = 1'b1;
            end
            default: ;
        endcase
    end

    assign rdata_o = rdata_q;

    // Request capture and read gather
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            off_q   <= '0;
            len_q   <= '0;
            cnt_q   <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
            write_q <= 1'b0;
        end else begin
            unique case (state_q)
                ACC_IDLE: begin
                    if (start_i) begin
                        off_q   <= off_i;
                        len_q   <= len_i;
                        cnt_q   <= '0;
                        wdata_q <= wdata_i;
                        write_q <= write_i;
                        rdata_q <= '0;
                    end
                end
                ACC_BEAT: begin
                    if (!write_q && in_win) begin
                        rdata_q[lane +: 8] <= rd_byte_i;
                    end
                    cnt_q <= cnt_q + 1'b1;
                end
                ACC_DONE: ;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/gpe_regfile.sv
module gpe_regfile #(
    parameter int GPE_BYTES = 2,
    parameter int WIN       = 2 * GPE_BYTES,
    parameter int OFF_W     = $clog2(WIN),
    parameter int GPE_W     = 8 * GPE_BYTES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bw_en_i,
    input  logic [OFF_W-1:0] b_off_i,
    input  logic [7:0]       bw_data_i,
    input  logic [GPE_W-1:0] set_i,
    output logic [7:0]       rd_byte_o,
    output logic [GPE_W-1:0] sts_o,
    output logic [GPE_W-1:0] en_o
);

    logic [GPE_W-1:0] sts_q;
    logic [GPE_W-1:0] en_q;

    for (genvar b = 0; b < GPE_BYTES; b++) begin : g_byte
        logic       sts_hit;
        logic       en_hit;
        logic [7:0] clr;

        assign sts_hit = bw_en_i && (b_off_i == OFF_W'(b));
        assign en_hit  = bw_en_i && (b_off_i == OFF_W'(GPE_BYTES + b));
        assign clr     = sts_hit ? bw_data_i : 8'h00;

        // Status: write-one-to-clear, a set in the same clock wins.
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sts_q[8*b +: 8] <= 8'h00;
            end else begin
                sts_q[8*b +: 8] <= (sts_q[8*b +: 8] & ~clr) | set_i[8*b +: 8];
            end
        end

        // Enable: plain read/write.
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                en_q[8*b +: 8] <= 8'h00;
            end else if (en_hit) begin
                en_q[8*b +: 8] <= bw_data_i;
            end
        end
    end

    always_comb begin
        rd_byte_o = 8'h00;
        for (int i = 0; i < GPE_BYTES; i++) begin
            if (b_off_i == OFF_W'(i))             rd_byte_o = sts_q[8*i +: 8];
            if (b_off_i == OFF_W'(GPE_BYTES + i)) rd_byte_o = en_q[8*i +: 8];
        end
    end

    assign sts_o = sts_q;
    assign en_o  = en_q;

endmodule

// File: rtl/gpe_sci_combine.sv
module gpe_sci_combine
    import gpe_sci_pkg::*;
#(
    parameter int FIX_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [FIX_W-1:0] fix_sts_i,
    input  logic [FIX_W-1:0] fix_en_i,
    input  logic [7:0]       gpe_sts0_i,
    input  logic [7:0]       gpe_en0_i,
    output logic             sci_o,
    output logic             tmr_arm_o
);

    localparam logic [FIX_W-1:0] FIX_MASK = FIX_W'(fix_sci_mask16());
    localparam logic [7:0]       GPE_MASK = gpe_sci_mask8();

    logic fix_hit;
    logic gpe_hit;
    logic arm_d;
    logic sci_q;
    logic arm_q;

    assign fix_hit = |(fix_sts_i & fix_en_i & FIX_MASK);
    assign gpe_hit = |(gpe_sts0_i & gpe_en0_i & GPE_MASK);
    assign arm_d   = fix_en_i[FIX_TMR_BIT] && !fix_sts_i[FIX_TMR_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sci_q <= 1'b0;
            arm_q <= 1'b0;
        end else begin
            sci_q <= fix_hit || gpe_hit;
            arm_q <= arm_d;
        end
    end

    assign sci_o     = sci_q;
    assign tmr_arm_o = arm_q;

endmodule

// File: rtl/gpe_sci_aggregator.sv
module gpe_sci_aggregator
    import gpe_sci_pkg::*;
#(
    parameter int GPE_BYTES = 2,
    parameter int FIX_W     = 16,
    parameter int WIN       = 2 * GPE_BYTES,
    parameter int OFF_W     = $clog2(WIN),
    parameter int GPE_W     = 8 * GPE_BYTES
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  acc_start_i,
    input  logic                  acc_write_i,
    input  logic [OFF_W-1:0]      acc_off_i,
    input  logic [ACC_LEN_W-1:0]  acc_len_i,
    input  logic [ACC_DATA_W-1:0] acc_wdata_i,
    output logic                  acc_busy_o,
    output logic                  acc_done_o,
    output logic [ACC_DATA_W-1:0] acc_rdata_o,
    input  logic [GPE_W-1:0]      evt_set_i,
    input  logic [FIX_W-1:0]      fix_sts_i,
    input  logic [FIX_W-1:0]      fix_en_i,
    output logic                  sci_o,
    output logic                  tmr_arm_o
);

    logic             bw_en;
    logic [OFF_W-1:0] b_off;
    logic [7:0]       bw_data;
    logic [7:0]       rd_byte;
    logic [GPE_W-1:0] sts_w;
    logic [GPE_W-1:0] en_w;

    gpe_acc_fsm #(
        .WIN   (WIN),
        .OFF_W (OFF_W)
    ) u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (acc_start_i),
        .write_i   (acc_write_i),
        .off_i     (acc_off_i),
        .len_i     (acc_len_i),
        .wdata_i   (acc_wdata_i),
        .rd_byte_i (rd_byte),
        .busy_o    (acc_busy_o),
        .done_o    (acc_done_o),
        .rdata_o   (acc_rdata_o),
        .bw_en_o   (bw_en),
        .b_off_o   (b_off),
        .bw_data_o (bw_data)
    );

    gpe_regfile #(
        .GPE_BYTES (GPE_BYTES),
        .WIN       (WIN),
        .OFF_W     (OFF_W),
        .GPE_W     (GPE_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bw_en_i   (bw_en),
        .b_off_i   (b_off),
        .bw_data_i (bw_data),
        .set_i     (evt_set_i),
        .rd_byte_o (rd_byte),
        .sts_o     (sts_w),
        .en_o      (en_w)
    );

    gpe_sci_combine #(
        .FIX_W (FIX_W)
    ) u_sci (
        .clk        (clk),
        .rst_n      (rst_n),
        .fix_sts_i  (fix_sts_i),
        .fix_en_i   (fix_en_i),
        .gpe_sts0_i (sts_w[7:0]),
        .gpe_en0_i  (en_w[7:0]),
        .sci_o      (sci_o),
        .tmr_arm_o  (tmr_arm_o)
    );

endmodule

// File: rtl/gpe_sci_aggregator_chk.sv
module gpe_sci_aggregator_chk
    import gpe_sci_pkg::*;
#(
    parameter int GPE_W = 16,
    parameter int FIX_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [GPE_W-1:0] evt_set_i,
    input logic [FIX_W-1:0] fix_sts_i,
    input logic [FIX_W-1:0] fix_en_i,
    input logic             sci_o,
    input logic             tmr_arm_o,
    input logic             acc_busy_o,
    input logic             acc_done_o,
    input logic [GPE_W-1:0] sts_q,
    input logic [GPE_W-1:0] en_q
);

    logic src_fix;
    logic src_gpe;
    assign src_fix = |(fix_sts_i & fix_en_i & FIX_W'(fix_sci_mask16()));
    assign src_gpe = |(sts_q[7:0] & en_q[7:0] & gpe_sci_mask8());

    // R1: quiet outputs while reset is held
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |-> (!sci_o && !tmr_arm_o && !acc_busy_o));

    // R6, R7, R8: SCI follows last clock's sources
    a_r8_sci_follows: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (sci_o == $past(src_fix || src_gpe)));

    // R9: timer arm request
    a_r9_tmr_arm: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (tmr_arm_o == $past(fix_en_i[FIX_TMR_BIT] && !fix_sts_i[FIX_TMR_BIT])));

    // R4: every set pulse lands in status
    a_r4_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && (|$past(evt_set_i))) |-> ((sts_q & $past(evt_set_i)) == $past(evt_set_i)));

    // R5: done lasts one clock
    a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        acc_done_o |=> !acc_done_o);

    // R10: done never without busy, busy drops after done
    a_r10_release: assert property (@(posedge clk) disable iff (!rst_n)
        acc_done_o |=> !acc_busy_o);

endmodule

bind gpe_sci_aggregator gpe_sci_aggregator_chk #(
    .GPE_W (GPE_W),
    .FIX_W (FIX_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt_set_i  (evt_set_i),
    .fix_sts_i  (fix_sts_i),
    .fix_en_i   (fix_en_i),
    .sci_o      (sci_o),
    .tmr_arm_o  (tmr_arm_o),
    .acc_busy_o (acc_busy_o),
    .acc_done_o (acc_done_o),
    .sts_q      (sts_w),
    .en_q       (en_w)
);

// File: tb/gpe_sci_aggregator_test.sv
module gpe_sci_aggregator_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_start = 1'b0;
    logic        acc_write = 1'b0;
    logic [1:0]  acc_off = '0;
    logic [1:0]  acc_len = '0;
    logic [31:0] acc_wdata = '0;
    logic        acc_busy;
    logic        acc_done;
    logic [31:0] acc_rdata;
    logic [15:0] evt_set = '0;
    logic [15:0] fix_sts = '0;
    logic [15:0] fix_en = '0;
    logic        sci;
    logic        tmr_arm;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    gpe_sci_aggregator uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .acc_start_i (acc_start),
        .acc_write_i (acc_write),
        .acc_off_i   (acc_off),
        .acc_len_i   (acc_len),
        .acc_wdata_i (acc_wdata),
        .acc_busy_o  (acc_busy),
        .acc_done_o  (acc_done),
        .acc_rdata_o (acc_rdata),
        .evt_set_i   (evt_set),
        .fix_sts_i   (fix_sts),
        .fix_en_i    (fix_en),
        .sci_o       (sci),
        .tmr_arm_o   (tmr_arm)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic acc(input logic wr, input logic [1:0] off, input logic [1:0] len,
                       input logic [31:0] wd, output logic [31:0] rd, output int cyc);
        @(negedge clk);
        acc_start = 1'b1; acc_write = wr; acc_off = off; acc_len = len; acc_wdata = wd;
        @(negedge clk);
        acc_start = 1'b0;
        cyc = 1;
        while (!acc_done && cyc < 50) begin
            @(negedge clk);
            cyc++;
        end
        rd = acc_rdata;
    endtask

    task automatic wr(input logic [1:0] off, input logic [1:0] len, input logic [31:0] wd);
        logic [31:0] d; int c;
        acc(1'b1, off, len, wd, d, c);
        @(negedge clk);   // let SCI register follow
    endtask

    task automatic rd(input logic [1:0] off, input logic [1:0] len, output logic [31:0] d);
        int c;
        acc(1'b0, off, len, 32'h0, d, c);
    endtask

    task automatic pulse(input logic [15:0] v);
        @(negedge clk); evt_set = v;
        @(negedge clk); evt_set = '0;
        @(negedge clk);
    endtask

    task automatic set_fix(input logic [15:0] s, input logic [15:0] e);
        @(negedge clk); fix_sts = s; fix_en = e;
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] d; int c;
        chk("R1 sci", {31'b0, sci}, 32'h0);
        chk("R1 tmr_arm", {31'b0, tmr_arm}, 32'h0);
        chk("R1 busy", {31'b0, acc_busy}, 32'h0);
        acc(1'b0, 2'd0, 2'd3, 32'h0, d, c);
        chk("R1 window zero", d, 32'h0);
        chk("R5 four-byte latency", c, 5);
        acc(1'b0, 2'd1, 2'd0, 32'h0, d, c);
        chk("R5 one-byte latency", c, 2);
    endtask

    task automatic t_enable_rw();
        logic [31:0] d;
        wr(2'd2, 2'd1, 32'h0000_A55A);
        rd(2'd0, 2'd3, d);
        chk("R2 enable readback layout", d, 32'hA55A_0000);
        chk("R7 enable alone no sci", {31'b0, sci}, 32'h0);
        wr(2'd2, 2'd1, 32'h0);
    endtask

    task automatic t_window_edge();
        logic [31:0] d;
        wr(2'd3, 2'd3, 32'h3322_11C3);
        rd(2'd3, 2'd3, d);
        chk("R5 bytes past window read 0", d, 32'h0000_00C3);
        rd(2'd2, 2'd1, d);
        chk("R5 past-window write ignored", d, 32'h0000_C300);
        wr(2'd3, 2'd0, 32'h0);
    endtask

    task automatic t_w1c();
        logic [31:0] d;
        pulse(16'h8106);
        rd(2'd0, 2'd1, d);
        chk("R4 set pulses land", d, 32'h0000_8106);
        wr(2'd0, 2'd0, 32'h0000_0002);
        rd(2'd0, 2'd1, d);
        chk("R3 w1c clears only ones", d, 32'h0000_8104);
        wr(2'd0, 2'd1, 32'h0000_FFFF);
        rd(2'd0, 2'd1, d);
        chk("R3 w1c clears all", d, 32'h0);
    endtask

    task automatic t_set_wins();
        logic [31:0] d;
        @(negedge clk);
        acc_start = 1'b1; acc_write = 1'b1; acc_off = 2'd0; acc_len = 2'd0; acc_wdata = 32'h2;
        @(negedge clk);
        acc_start = 1'b0; evt_set = 16'h0002;   // lands on the write beat
        @(negedge clk);
        evt_set = '0;
        while (!acc_done) @(negedge clk);
        rd(2'd0, 2'd0, d);
        chk("R4 set beats clear", d, 32'h0000_0002);
        wr(2'd0, 2'd1, 32'hFFFF);
    endtask

    task automatic t_gpe_sci();
        pulse(16'hFFFF);
        wr(2'd2, 2'd1, 32'h0000_FFF9);
        chk("R7 non-hotplug bits no sci", {31'b0, sci}, 32'h0);
        wr(2'd2, 2'd0, 32'h02);
        chk("R7 pci hotplug bit1 sci", {31'b0, sci}, 32'h1);
        wr(2'd0, 2'd0, 32'h02);
        chk("R7 cleared bit1 drops sci", {31'b0, sci}, 32'h0);
        wr(2'd2, 2'd0, 32'h04);
        chk("R7 cpu hotplug bit2 sci", {31'b0, sci}, 32'h1);
        wr(2'd0, 2'd1, 32'hFFFF);
        chk("R7 status cleared no sci", {31'b0, sci}, 32'h0);
        wr(2'd2, 2'd1, 32'h0);
    endtask

    task automatic t_fix_sci();
        int on_bits[4] = '{0, 5, 8, 10};
        int off_bits[5] = '{1, 4, 9, 11, 15};
        foreach (on_bits[i]) begin
            set_fix(16'(1) << on_bits[i], 16'hFFFF);
            chk($sformatf("R6 fixed bit %0d raises sci", on_bits[i]), {31'b0, sci}, 32'h1);
        end
        foreach (off_bits[i]) begin
            set_fix(16'(1) << off_bits[i], 16'hFFFF);
            chk($sformatf("R6 fixed bit %0d ignored", off_bits[i]), {31'b0, sci}, 32'h0);
        end
        set_fix(16'hFFFF, 16'h0000);
        chk("R6 enable masks", {31'b0, sci}, 32'h0);
        set_fix(16'h0, 16'h0);
    endtask

    task automatic t_tmr();
        set_fix(16'h0000, 16'h0001);
        chk("R9 arm when enabled and clear", {31'b0, tmr_arm}, 32'h1);
        set_fix(16'h0001, 16'h0001);
        chk("R9 no arm when status set", {31'b0, tmr_arm}, 32'h0);
        set_fix(16'h0000, 16'h0000);
        chk("R9 no arm when disabled", {31'b0, tmr_arm}, 32'h0);
        set_fix(16'hFFFE, 16'hFFFF);
        chk("R9 other bits irrelevant", {31'b0, tmr_arm}, 32'h1);
        set_fix(16'h0, 16'h0);
    endtask

    task automatic t_lag();
        set_fix(16'h0000, 16'h0100);
        chk("R8 start low", {31'b0, sci}, 32'h0);
        @(negedge clk); fix_sts = 16'h0100;
        #1;
        chk("R8 no same-clock change", {31'b0, sci}, 32'h0);
        @(negedge clk);
        chk("R8 follows after one clock", {31'b0, sci}, 32'h1);
        set_fix(16'h0, 16'h0);
    endtask

    task automatic t_busy();
        logic [31:0] d;
        int dones = 0;
        @(negedge clk);
        acc_start = 1'b1; acc_write = 1'b0; acc_off = 2'd0; acc_len = 2'd3;
        @(negedge clk);
        acc_write = 1'b1; acc_off = 2'd2; acc_len = 2'd0; acc_wdata = 32'hFF;
        chk("R10 busy during request", {31'b0, acc_busy}, 32'h1);
        @(negedge clk);
        acc_start = 1'b0;
        for (int i = 0; i < 12; i++) begin
            if (acc_done) dones++;
            @(negedge clk);
        end
        chk("R10 one done pulse", dones, 1);
        rd(2'd2, 2'd0, d);
        chk("R10 busy start wrote nothing", d, 32'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_enable_rw();
        t_window_edge();
        t_w1c();
        t_set_wins();
        t_gpe_sci();
        t_fix_sci();
        t_tmr();
        t_lag();
        t_busy();
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule